// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

This block derives the pixel clock of one display output path inside a single-clock design. Each candidate source clock reaches the block as a one-cycle tick strobe in the core clock domain. A 3-bit select field picks one of these strobes. The block then either divides the chosen source by an integer ratio of two or more, or passes it straight through when a bypass bit is set. The result is given as a pixel-clock level and as an end-of-period strobe. The ratio now in force is reported on a readback port.

All settings live in one 32-bit configuration word. Software can write the whole word at once. It can also use a divider-only write that replaces the divide field and the bypass bit and keeps every other bit of the word. The stored divide code is the ratio minus two, so a word of zero gives divide-by-2. New settings are taken into use only when an output period ends, or at once while the output is disabled. Two output paths are built by placing two instances of the same module.

Top module: `pxclk_div`

## Requirements
- R1: The divide code sits in word bits [9:0]. With bypass clear, code N gives an output period of N+2 selected source ticks, and `ratio` reports N+2 once the setting is active.
- R2: After reset the configuration word reads 0, `ratio` reads 2, and `pix_clk` and `pix_tick` are low.
- R3: When word bit 13 (bypass) is set, `ratio` reads 1 whatever the divide code is. `pix_clk` then equals the selected source tick in every cycle, and `pix_tick` fires on each selected tick.
- R4: Word bits [12:10] pick `src_tick[sel]`, and only ticks of that source advance the output. Encoding 0 picks input 0, the LCD PLL source. A select value with no matching input gives no ticks.
- R5: A divider-only write (`div_we`) replaces bits [9:0] and bit 13 and leaves all other bits unchanged. A full write (`cfg_we`) replaces the whole word and takes priority when both writes occur in the same cycle.
- R6: While enabled, a changed setting takes effect only after the last source tick of the current output period. `ratio` stays the same in every other cycle, so the output never produces a shortened period.
- R7: For a ratio R of two or more, each period begins with a high phase of floor(R/2) source ticks followed by a low phase of the remaining ticks. `pix_tick` is high during the last source tick of the period.
- R8: While `en` is low, `pix_clk` and `pix_tick` are held low, the stored settings are taken into use at once, and the period counter returns to the start of the high phase.
- R9: `cfg_rdata` always returns the stored configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Output enable; low holds the output low and restarts the period |
| src_tick | input | NSRC (8) | One tick strobe per candidate source clock |
| cfg_we | input | 1 | Full configuration word write |
| cfg_wdata | input | 32 | Data for a full write |
| div_we | input | 1 | Divider-only write |
| div_code | input | 10 | New divide code (ratio minus two) |
| div_byp | input | 1 | New bypass bit |
| cfg_rdata | output | 32 | Stored configuration word |
| ratio | output | 11 | Divide ratio currently in force (1 when bypassed) |
| pix_clk | output | 1 | Pixel clock level |
| pix_tick | output | 1 | Strobe on the last source tick of each output period |

## Verification
The hardest case to reach is a divider change that arrives in the middle of a running period. The new word has to sit unused while the old period runs out, and it has to be taken into use exactly at the wrap. The stimulus sets up a divide-by-4 period and waits one source tick into it. It then issues a divider-only write and follows `ratio`, `pix_clk` and `pix_tick` cycle by cycle across the wrap. A second awkward case is a source that ticks only every other core cycle, combined with a select value whose input never ticks. These are driven from a bench-generated toggling strobe on input 1.

// File: rtl/pxclk_div_pkg.sv
`timescale 1ns/1ps
package pxclk_div_pkg;
  localparam int WORD_W   = 32;
  localparam int DIV_W    = 10;
  localparam int DIV_LSB  = 0;
  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = 10;
  localparam int BYP_BIT  = 13;
  localparam int RAT_W    = DIV_W + 1;

  // Ratio encoded by a divide code and bypass bit.
  function automatic logic [RAT_W-1:0] eff_ratio(input logic byp, input logic [DIV_W-1:0] code);
    if (byp) return RAT_W'(1);
    return RAT_W'(code) + RAT_W'(2);
  endfunction

  // Number of source ticks in the high phase of a period.
  function automatic logic [RAT_W-1:0] high_len(input logic [RAT_W-1:0] r);
    return r >> 1;
  endfunction
endpackage

// File: rtl/pxclk_cfg_reg.sv
`timescale 1ns/1ps
module pxclk_cfg_reg
  import pxclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              div_byp,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (cfg_we) begin
      word <= cfg_wdata;
    end else if (div_we) begin
      word[DIV_LSB +: DIV_W] <= div_code;
      word[BYP_BIT]          <= div_byp;
    end
  end
endmodule

// File: rtl/pxclk_tick_mux.sv
`timescale 1ns/1ps
module pxclk_tick_mux
  import pxclk_div_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]  ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [NSRC-1:0] hit;
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = ticks[i] && (sel == SEL_W'(i));
  end
  assign tick = |hit;
endmodule

// File: rtl/pxclk_div_core.sv
`timescale 1ns/1ps
module pxclk_div_core
  import pxclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [DIV_W-1:0] new_code,
  input  logic             new_byp,
  input  logic [SEL_W-1:0] new_sel,
  output logic [SEL_W-1:0] act_sel,
  output logic [RAT_W-1:0] act_ratio,
  output logic             pix_clk,
  output logic             pix_tick
);
  logic [RAT_W-1:0] cnt;
  logic             byp_q;
  logic             last;
  logic             wrap;

  assign last = (cnt == act_ratio - RAT_W'(1));
  assign wrap = en && tick && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act_ratio <= eff_ratio(1'b0, '0);
      byp_q     <= 1'b0;
      act_sel   <= '0;
    end else if (!en || wrap) begin
      cnt       <= '0;
      act_ratio <= eff_ratio(new_byp, new_code);
      byp_q     <= new_byp;
      act_sel   <= new_sel;
    end else if (tick) begin
      cnt <= cnt + RAT_W'(1);
    end
  end

  assign pix_tick = wrap;
  assign pix_clk  = en && (byp_q ? tick : (cnt < high_len(act_ratio)));
endmodule

// File: rtl/pxclk_div.sv
`timescale 1ns/1ps
module pxclk_div
  import pxclk_div_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              div_byp,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic [RAT_W-1:0]  ratio,
  output logic              pix_clk,
  output logic              pix_tick
);
  localparam int MAX_SRC = 1 << SEL_W;
  if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
    $error("NSRC out of range");
  end

  logic [WORD_W-1:0] word;
  logic [SEL_W-1:0]  act_sel;
  logic              sel_tick;

  pxclk_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .div_we(div_we), .div_code(div_code), .div_byp(div_byp), .word(word)
  );

  pxclk_tick_mux #(.NSRC(NSRC)) u_mux (
    .ticks(src_tick), .sel(act_sel), .tick(sel_tick)
  );

  pxclk_div_core u_core (
    .clk(clk), .rst(rst), .en(en), .tick(sel_tick),
    .new_code(word[DIV_LSB +: DIV_W]), .new_byp(word[BYP_BIT]),
    .new_sel(word[SEL_LSB +: SEL_W]),
    .act_sel(act_sel), .act_ratio(ratio), .pix_clk(pix_clk), .pix_tick(pix_tick)
  );

  assign cfg_rdata = word;
endmodule

// File: rtl/pxclk_div_chk.sv
`timescale 1ns/1ps
module pxclk_div_chk
  import pxclk_div_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              cfg_we,
  input logic              div_we,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic [RAT_W-1:0]  ratio,
  input logic              pix_clk,
  input logic              pix_tick,
  input logic              sel_tick
);
  localparam logic [WORD_W-1:0] KEEP = ~((WORD_W'(1) << DIV_W) - 1) & ~(WORD_W'(1) << BYP_BIT);

  p_ratio_nonzero_r1: assert property (@(posedge clk) disable iff (rst) ratio != '0);

  p_tick_from_source_r4: assert property (@(posedge clk) disable iff (rst) pix_tick |-> sel_tick);

  p_keep_other_bits_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(div_we) && !$past(cfg_we)) |-> ((cfg_rdata & KEEP) == ($past(cfg_rdata) & KEEP)));

  p_ratio_holds_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(pix_tick)) |-> $stable(ratio));

  p_period_starts_high_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(pix_tick) && en && ratio > RAT_W'(1)) |-> pix_clk);

  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!pix_clk && !pix_tick));
endmodule

bind pxclk_div pxclk_div_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .div_we(div_we),
  .cfg_rdata(cfg_rdata), .ratio(ratio), .pix_clk(pix_clk),
  .pix_tick(pix_tick), .sel_tick(sel_tick)
);

// File: tb/pxclk_div_tb_top.sv
`timescale 1ns/1ps
module pxclk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        s1 = 1'b0;
  logic [7:0]  src_tick;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        div_we = 1'b0;
  logic [9:0]  div_code = '0;
  logic        div_byp = 1'b0;
  logic [31:0] cfg_rdata;
  logic [10:0] ratio;
  logic        pix_clk;
  logic        pix_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign src_tick = {6'b0, s1, 1'b1};

  always #2.5 clk = ~clk;

  pxclk_div dut_i (
    .clk(clk), .rst(rst), .en(en), .src_tick(src_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .div_we(div_we),
    .div_code(div_code), .div_byp(div_byp), .cfg_rdata(cfg_rdata),
    .ratio(ratio), .pix_clk(pix_clk), .pix_tick(pix_tick)
  );

  // Source 1 ticks every other core cycle.
  initial begin
    forever begin
      @(negedge clk);
      s1 = ~s1;
    end
  end

  // {code, bypass, expected ratio, expected high ticks}; source 0 ticks every cycle
  localparam logic [32:0] VEC [0:5] = '{
    {10'd0,    1'b0, 11'd2,    11'd1},
    {10'd1,    1'b0, 11'd3,    11'd1},
    {10'd2,    1'b0, 11'd4,    11'd2},
    {10'd7,    1'b0, 11'd9,    11'd4},
    {10'd1023, 1'b0, 11'd1025, 11'd512},
    {10'd9,    1'b1, 11'd1,    11'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nstep();
    @(negedge clk);
    #1;
  endtask

  task automatic load_word(input logic [31:0] w);
    @(negedge clk);
    en = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    en = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int highs, ticks, miss;
    logic [31:0] w;
    // R2: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R2 word in reset", cfg_rdata, 32'h0);
    check("R2 ratio in reset", {21'b0, ratio}, 32'd2);
    check("R2 pix_clk in reset", {31'b0, pix_clk}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    nstep();
    check("R2 word after reset", cfg_rdata, 32'h0);
    check("R2 ratio after reset", {21'b0, ratio}, 32'd2);

    // R1 R3 R7: vector walk on source 0
    for (int v = 0; v < 6; v++) begin
      int r;
      w = 32'h0;
      w[9:0] = VEC[v][32:23];
      w[13]  = VEC[v][22];
      load_word(w);
      r = int'(VEC[v][21:11]);
      check("R1 R3 ratio readback", {21'b0, ratio}, {21'b0, VEC[v][21:11]});
      highs = 0;
      ticks = 0;
      for (int k = 0; k < r; k++) begin
        if (pix_clk) highs++;
        if (pix_tick) ticks++;
        if (k == r - 1) check("R7 tick on last source tick", {31'b0, pix_tick}, 32'd1);
        if (k < r - 1) nstep();
      end
      check("R7 high phase length", highs, int'(VEC[v][10:0]));
      check("R7 one tick per period", ticks, 1);
    end

    // R8: disabled output stays low, settings load at once
    @(negedge clk);
    en = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0005;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    highs = 0;
    ticks = 0;
    for (int k = 0; k < 6; k++) begin
      if (pix_clk) highs++;
      if (pix_tick) ticks++;
      nstep();
    end
    check("R8 pix_clk low when disabled", highs, 0);
    check("R8 pix_tick low when disabled", ticks, 0);
    check("R8 setting loaded while disabled", {21'b0, ratio}, 32'd7);
    @(negedge clk);
    en = 1'b1;
    #1;
    check("R8 restart in high phase", {31'b0, pix_clk}, 32'd1);

    // R5 R9: full write, divider-only write, priority
    @(negedge clk);
    en = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = 32'hF0F0_C807;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R9 readback of full write", cfg_rdata, 32'hF0F0_C807);
    @(negedge clk);
    div_we = 1'b1;
    div_code = 10'h155;
    div_byp = 1'b1;
    @(negedge clk);
    div_we = 1'b0;
    #1;
    check("R5 divider-only write keeps other bits", cfg_rdata, 32'hF0F0_E955);
    @(negedge clk);
    div_we = 1'b1;
    div_code = 10'h3;
    div_byp = 1'b0;
    cfg_we = 1'b1;
    cfg_wdata = 32'h1234_0002;
    @(negedge clk);
    div_we = 1'b0;
    cfg_we = 1'b0;
    #1;
    check("R5 full write has priority", cfg_rdata, 32'h1234_0002);

    // R6: mid-period change waits for the wrap
    load_word(32'h0000_0002);
    check("R6 ratio before change", {21'b0, ratio}, 32'd4);
    @(negedge clk);
    div_we = 1'b1;
    div_code = 10'd0;
    div_byp = 1'b0;
    nstep();
    div_we = 1'b0;
    check("R6 ratio held mid-period", {21'b0, ratio}, 32'd4);
    check("R6 old low phase kept", {31'b0, pix_clk}, 32'd0);
    nstep();
    check("R6 ratio held on last tick", {21'b0, ratio}, 32'd4);
    check("R6 old period ends", {31'b0, pix_tick}, 32'd1);
    nstep();
    check("R6 new ratio after wrap", {21'b0, ratio}, 32'd2);
    check("R6 new period starts high", {31'b0, pix_clk}, 32'd1);

    // R4: source select
    load_word(32'h0000_0400);
    ticks = 0;
    for (int k = 0; k < 16; k++) begin
      if (pix_tick) ticks++;
      nstep();
    end
    check("R4 source 1 at half rate gives 4 periods", ticks, 4);
    load_word(32'h0000_0800);
    ticks = 0;
    for (int k = 0; k < 8; k++) begin
      if (pix_tick) ticks++;
      nstep();
    end
    check("R4 silent source gives no ticks", ticks, 0);

    // R3: bypass follows source 1 regardless of divide code
    load_word(32'h0000_2409);
    check("R3 bypass ratio", {21'b0, ratio}, 32'd1);
    miss = 0;
    ticks = 0;
    for (int k = 0; k < 8; k++) begin
      if (pix_clk !== s1) miss++;
      if (pix_tick) ticks++;
      nstep();
    end
    check("R3 pix_clk follows selected source", miss, 0);
    check("R3 tick on each source tick", ticks, 4);

    finish_run();
  end
endmodule